// File: doc/BRIEF.md
# Scanline Sprite Evaluator

This block picks which sprites appear on the next scanline. Each line it reads the 64 vertical positions of a sprite attribute table held in video RAM, in table order. It keeps the first eight sprites whose vertical extent covers the requested line. For each kept sprite it then reads the horizontal position and pattern byte and stores them in an eight-slot buffer. A later pixel stage reads that buffer: slot 0 has the highest priority and then the slots follow in table order. If a ninth covering sprite exists, the block raises a one-cycle overflow pulse.

A scan is started by a one-cycle `start` strobe. The line number, table base and mode bits are captured on that strobe, so they may change while the scan runs. A `start` while a scan is running abandons that scan and begins a new one. The buffer, the count and `done` stay steady from the end of a scan until the next strobe.

The video RAM interface is the only stream. A request is offered with `vram_req` and `vram_addr` and is taken on a cycle where `vram_ready` is also high. The byte then appears on `vram_data` exactly one cycle later. While the request is not taken, the block holds it and its address unchanged. Back-pressure only stretches the scan and never alters its result. At most one read is in flight at a time.

Top module: `sprite_line_eval`

## Requirements
- R1: After `start`, vertical bytes are read at address {`sat_base`, 8'h00 + n} for n = 0, 1, 2, ... in increasing order. No read touches table offsets 0x40 to 0x7F, and every read carries `sat_base` in address bits 13:8.
- R2: A stored vertical byte Y places the sprite's first line at Y+1, counted modulo 256. The sprite covers line L when (L − Y − 1) mod 256 is less than the sprite height.
- R3: Sprite height is 8 lines. It is 16 lines when `tall_en` is 1, and it doubles when `zoom_en` is 1, giving 8, 16, 16 or 32 lines.
- R4: The scan stops after table entry 63, or when a ninth covering sprite is found. In the second case `overflow` pulses high for exactly one cycle before `done`. At most 8 entries are kept, and `ent_count` gives how many.
- R5: With `lines192` = 1, a vertical byte of 208 ends the scan at once: that sprite and all later ones are neither kept nor counted for overflow. With `lines192` = 0, the value 208 is an ordinary position.
- R6: Slot k (bits [8k+7:8k] of `ent_x`, and so on) holds the k-th covering sprite in table order.
- R7: A kept sprite n takes its horizontal byte from table offset 0x80+2n and its pattern byte from offset 0x81+2n. Overflow is judged without looking at these bytes.
- R8: `ent_pat` bit 0 is the pattern byte's bit 0 when `tall_en` is 0. When `tall_en` is 1, it is 0 for the upper 8 sprite rows and 1 for the lower 8.
- R9: `ent_pat` bit 8 equals `pat_bank`, and bits 7:1 equal pattern byte bits 7:1.
- R10: `ent_row` is the row within the 8x8 pattern for the requested line: bits 2:0 of (L − Y − 1), shifted right by one first when `zoom_en` is 1.
- R11: `vram_data` is taken as the answer to a read accepted one cycle earlier. An unaccepted request is held with a stable address until it is accepted.
- R12: With `vram_ready` held high, `done` rises within 342 cycles of `start`. Then `done`, `ent_count` and the slots hold until the next `start`, and no reads are issued. After reset `done`, `ent_count`, `overflow` and `vram_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle strobe: capture settings and begin a scan |
| next_line | input | 8 | Line number to evaluate |
| sat_base | input | 6 | Address bits 13:8 of the attribute table |
| tall_en | input | 1 | 1 = 16-line sprites using two patterns |
| zoom_en | input | 1 | 1 = sprite height doubled |
| pat_bank | input | 1 | Pattern index bit 8 |
| lines192 | input | 1 | 1 = 192-line mode, where 208 ends the table |
| vram_req | output | 1 | Read request valid |
| vram_addr | output | 14 | Read address |
| vram_ready | input | 1 | Read request accepted when high with `vram_req` |
| vram_data | input | 8 | Read data, one cycle after acceptance |
| ent_x | output | 64 | Horizontal byte of slot k at bits [8k+7:8k] |
| ent_pat | output | 72 | Pattern index of slot k at bits [9k+8:9k] |
| ent_row | output | 24 | Pattern row of slot k at bits [3k+2:3k] |
| ent_count | output | 4 | Number of valid slots, 0 to 8 |
| done | output | 1 | High from scan end until the next `start` |
| overflow | output | 1 | One-cycle pulse: a ninth covering sprite was found |

## Verification
The bench targets the following corner cases:
- **Wrap-around at line 0.** A stored 255 must cover line 0. A design that compares without modular wrap would drop those sprites.
- **Terminator value 208.** It is swept in both line modes. Treating it as a stop outside 192-line mode, or letting it count as a ninth sprite, shows up as a short list or a false overflow pulse.
- **Dense tables that pass eight hits.** These check the single overflow pulse and the exact number of vertical reads. A scan that stops at eight, or one that runs to the end, is caught by the read count.
- **Tall and zoomed patterns.** The bottom-half pattern bit and the halved row are compared for every slot. Back-pressure is applied at random to show that a stalled request never shifts the data pairing.

// File: rtl/spr_eval_pkg.sv
package spr_eval_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SCAN_Y,
    ST_FETCH,
    ST_DONE
  } scan_state_t;

  typedef struct packed {
    logic [7:0] line;
    logic       tall;
    logic       zoom;
    logic       bank;
    logic       mode192;
  } scan_cfg_t;

  localparam logic [7:0] TERM_Y  = 8'd208;
  localparam logic [7:0] XP_OFS  = 8'h80;

endpackage

// File: rtl/spr_y_match.sv
module spr_y_match (
  input  logic [7:0] y_stored,
  input  logic [7:0] line,
  input  logic       tall,
  input  logic       zoom,
  output logic       hit,
  output logic [3:0] row
);
  logic [7:0] diff;
  logic [5:0] height;

  always_comb begin
    // first covered line is stored value plus one, modulo 256
    diff = line - y_stored - 8'd1;
    case ({tall, zoom})
      2'b00:   height = 6'd8;
      2'b01:   height = 6'd16;
      2'b10:   height = 6'd16;
      default: height = 6'd32;
    endcase
    hit = (diff < {2'b00, height});
    row = zoom ? diff[4:1] : diff[3:0];
  end
endmodule

// File: rtl/spr_slot_buf.sv
module spr_slot_buf #(
  parameter int NSLOT = 8,
  parameter int IDX_W = 6,
  localparam int SLOT_W = $clog2(NSLOT),
  localparam int CNT_W  = $clog2(NSLOT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  count,
  input  logic              y_we,
  input  logic [SLOT_W-1:0] y_slot,
  input  logic [IDX_W-1:0]  y_idx,
  input  logic [3:0]        y_row,
  input  logic              x_we,
  input  logic              p_we,
  input  logic [SLOT_W-1:0] xp_slot,
  input  logic [7:0]        xp_data,
  input  logic              tall,
  input  logic              bank,
  output logic [IDX_W-1:0]  idx_o [NSLOT],
  output logic [7:0]        x_o   [NSLOT],
  output logic [8:0]        pat_o [NSLOT],
  output logic [2:0]        row_o [NSLOT]
);
  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    logic [IDX_W-1:0] idx_q;
    logic [3:0]       row_q;
    logic [7:0]       x_q;
    logic [7:0]       p_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        idx_q <= '0;
        row_q <= '0;
        x_q   <= '0;
        p_q   <= '0;
      end else begin
        if (y_we && y_slot == SLOT_W'(k)) begin
          idx_q <= y_idx;
          row_q <= y_row;
        end
        if (x_we && xp_slot == SLOT_W'(k)) x_q <= xp_data;
        if (p_we && xp_slot == SLOT_W'(k)) p_q <= xp_data;
      end
    end

    assign idx_o[k] = idx_q;
    assign x_o[k]   = x_q;
    // tall sprites: bit 0 picks top or bottom pattern from the row
    assign pat_o[k] = {bank, p_q[7:1], tall ? row_q[3] : p_q[0]};
    assign row_o[k] = row_q[2:0];

    if (k < NSLOT - 1) begin : g_order
      // R6: kept slots follow table order
      a_r6_table_order: assert property (@(posedge clk) disable iff (!rst_n)
        (count > CNT_W'(k + 1)) |-> (idx_q < g_slot[k+1].idx_q));
    end
  end
endmodule

// File: rtl/spr_scan_ctrl.sv
module spr_scan_ctrl
  import spr_eval_pkg::*;
#(
  parameter int NSLOT  = 8,
  parameter int NSPR   = 64,
  parameter int ADDR_W = 14,
  parameter int BUDGET = 342,
  localparam int IDX_W  = $clog2(NSPR),
  localparam int SLOT_W = $clog2(NSLOT),
  localparam int CNT_W  = $clog2(NSLOT + 1),
  localparam int FI_W   = $clog2(2 * NSLOT + 1),
  localparam int BASE_W = ADDR_W - 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  scan_cfg_t         cfg_in,
  input  logic [BASE_W-1:0] base_in,
  output logic              vram_req,
  output logic [ADDR_W-1:0] vram_addr,
  input  logic              vram_ready,
  input  logic [7:0]        vram_data,
  input  logic [IDX_W-1:0]  slot_idx [NSLOT],
  output scan_cfg_t         cfg_q,
  output logic              y_we,
  output logic [SLOT_W-1:0] y_slot,
  output logic [IDX_W-1:0]  y_idx,
  output logic [3:0]        y_row,
  output logic              x_we,
  output logic              p_we,
  output logic [SLOT_W-1:0] xp_slot,
  output logic [CNT_W-1:0]  hits,
  output logic              done,
  output logic              overflow
);
  scan_state_t       st;
  logic [BASE_W-1:0] base_q;
  logic [IDX_W:0]    iss_idx;
  logic              pend;
  logic [IDX_W-1:0]  pend_idx;
  logic [FI_W-1:0]   fi;
  logic [FI_W-1:0]   pend_tag;
  logic [9:0]        act_cyc;

  logic              m_hit;
  logic [3:0]        m_row;

  spr_y_match u_match (
    .y_stored (vram_data),
    .line     (cfg_q.line),
    .tall     (cfg_q.tall),
    .zoom     (cfg_q.zoom),
    .hit      (m_hit),
    .row      (m_row)
  );

  logic            y_rsp, is_term, full, take, ovf_hit, y_last;
  logic            y_req, f_req, accept, f_rsp, f_last;
  logic [FI_W-1:0] fetch_total;
  logic [IDX_W-1:0] sel_idx;
  logic [7:0]      y_lo, xp_lo;

  always_comb begin
    y_rsp       = (st == ST_SCAN_Y) && pend;
    is_term     = cfg_q.mode192 && (vram_data == TERM_Y);
    full        = (hits == CNT_W'(NSLOT));
    take        = y_rsp && !is_term && m_hit && !full;
    ovf_hit     = y_rsp && !is_term && m_hit && full;
    y_last      = y_rsp && (is_term || ovf_hit || pend_idx == IDX_W'(NSPR - 1));
    fetch_total = FI_W'({hits, 1'b0});
    y_req       = (st == ST_SCAN_Y) && (iss_idx < (IDX_W + 1)'(NSPR)) && !y_last;
    f_req       = (st == ST_FETCH) && (fi < fetch_total);
    vram_req    = y_req || f_req;
    accept      = vram_req && vram_ready;
    f_rsp       = (st == ST_FETCH) && pend;
    f_last      = f_rsp && (pend_tag == fetch_total - FI_W'(1));
    sel_idx     = slot_idx[fi[SLOT_W:1]];
    y_lo        = 8'(iss_idx);
    xp_lo       = XP_OFS + 8'({sel_idx, 1'b0}) + 8'(fi[0]);
    vram_addr   = {base_q, (st == ST_FETCH) ? xp_lo : y_lo};
  end

  assign y_we    = take;
  assign y_slot  = hits[SLOT_W-1:0];
  assign y_idx   = pend_idx;
  assign y_row   = m_row;
  assign x_we    = f_rsp && !pend_tag[0];
  assign p_we    = f_rsp && pend_tag[0];
  assign xp_slot = pend_tag[SLOT_W:1];
  assign done    = (st == ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cfg_q    <= '0;
      base_q   <= '0;
      iss_idx  <= '0;
      hits     <= '0;
      pend     <= 1'b0;
      pend_idx <= '0;
      fi       <= '0;
      pend_tag <= '0;
      overflow <= 1'b0;
    end else if (start) begin
      st       <= ST_SCAN_Y;
      cfg_q    <= cfg_in;
      base_q   <= base_in;
      iss_idx  <= '0;
      hits     <= '0;
      pend     <= 1'b0;
      fi       <= '0;
      overflow <= 1'b0;
    end else begin
      overflow <= ovf_hit;
      pend     <= accept;
      if (accept) begin
        pend_idx <= iss_idx[IDX_W-1:0];
        pend_tag <= fi;
      end
      if (y_req && accept) iss_idx <= iss_idx + 1'b1;
      if (f_req && accept) fi <= fi + 1'b1;
      if (take) hits <= hits + 1'b1;
      if (y_last) st <= (hits == '0 && !take) ? ST_DONE : ST_FETCH;
      if (f_last) st <= ST_DONE;
    end
  end

  // cycles spent scanning, not counting stalls by the memory
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        act_cyc <= '0;
    else if (start)                    act_cyc <= '0;
    else if ((st == ST_SCAN_Y || st == ST_FETCH) && !(vram_req && !vram_ready)
             && act_cyc != '1)         act_cyc <= act_cyc + 1'b1;
  end

  // R11: a refused request stays put until taken
  a_r11_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (vram_req && !vram_ready && !start) |=> (vram_req && $stable(vram_addr)));

  // R4: never more than the slot count
  a_r4_hits_bound: assert property (@(posedge clk) disable iff (!rst_n)
    hits <= CNT_W'(NSLOT));

  // R4: overflow only with every slot taken
  a_r4_ovf_full: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> (hits == CNT_W'(NSLOT)));

  // R12: finished scan is quiet and stable
  a_r12_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !vram_req);

  a_r12_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(hits)));

  // R12: unstalled work fits the line budget
  a_r12_budget: assert property (@(posedge clk) disable iff (!rst_n)
    act_cyc <= 10'(BUDGET));
endmodule

// File: rtl/sprite_line_eval.sv
module sprite_line_eval
  import spr_eval_pkg::*;
#(
  parameter int NSLOT  = 8,
  parameter int NSPR   = 64,
  parameter int ADDR_W = 14,
  parameter int BUDGET = 342,
  localparam int IDX_W  = $clog2(NSPR),
  localparam int SLOT_W = $clog2(NSLOT),
  localparam int CNT_W  = $clog2(NSLOT + 1),
  localparam int BASE_W = ADDR_W - 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [7:0]           next_line,
  input  logic [BASE_W-1:0]    sat_base,
  input  logic                 tall_en,
  input  logic                 zoom_en,
  input  logic                 pat_bank,
  input  logic                 lines192,
  output logic                 vram_req,
  output logic [ADDR_W-1:0]    vram_addr,
  input  logic                 vram_ready,
  input  logic [7:0]           vram_data,
  output logic [NSLOT*8-1:0]   ent_x,
  output logic [NSLOT*9-1:0]   ent_pat,
  output logic [NSLOT*3-1:0]   ent_row,
  output logic [CNT_W-1:0]     ent_count,
  output logic                 done,
  output logic                 overflow
);
  scan_cfg_t         cfg_in, cfg_q;
  logic [IDX_W-1:0]  slot_idx [NSLOT];
  logic [7:0]        x_arr    [NSLOT];
  logic [8:0]        pat_arr  [NSLOT];
  logic [2:0]        row_arr  [NSLOT];
  logic              y_we, x_we, p_we;
  logic [SLOT_W-1:0] y_slot, xp_slot;
  logic [IDX_W-1:0]  y_idx;
  logic [3:0]        y_row;

  assign cfg_in = '{line: next_line, tall: tall_en, zoom: zoom_en,
                    bank: pat_bank, mode192: lines192};

  spr_scan_ctrl #(
    .NSLOT (NSLOT), .NSPR (NSPR), .ADDR_W (ADDR_W), .BUDGET (BUDGET)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .cfg_in     (cfg_in),
    .base_in    (sat_base),
    .vram_req   (vram_req),
    .vram_addr  (vram_addr),
    .vram_ready (vram_ready),
    .vram_data  (vram_data),
    .slot_idx   (slot_idx),
    .cfg_q      (cfg_q),
    .y_we       (y_we),
    .y_slot     (y_slot),
    .y_idx      (y_idx),
    .y_row      (y_row),
    .x_we       (x_we),
    .p_we       (p_we),
    .xp_slot    (xp_slot),
    .hits       (ent_count),
    .done       (done),
    .overflow   (overflow)
  );

  spr_slot_buf #(.NSLOT (NSLOT), .IDX_W (IDX_W)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .count   (ent_count),
    .y_we    (y_we),
    .y_slot  (y_slot),
    .y_idx   (y_idx),
    .y_row   (y_row),
    .x_we    (x_we),
    .p_we    (p_we),
    .xp_slot (xp_slot),
    .xp_data (vram_data),
    .tall    (cfg_q.tall),
    .bank    (cfg_q.bank),
    .idx_o   (slot_idx),
    .x_o     (x_arr),
    .pat_o   (pat_arr),
    .row_o   (row_arr)
  );

  for (genvar k = 0; k < NSLOT; k++) begin : g_flat
    assign ent_x[k*8 +: 8]   = x_arr[k];
    assign ent_pat[k*9 +: 9] = pat_arr[k];
    assign ent_row[k*3 +: 3] = row_arr[k];
  end
endmodule

// File: tb/sprite_line_eval_test.sv
module sprite_line_eval_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  next_line = '0;
  logic [5:0]  sat_base = '0;
  logic        tall_en = 1'b0, zoom_en = 1'b0, pat_bank = 1'b0, lines192 = 1'b0;
  logic        vram_req;
  logic [13:0] vram_addr;
  logic        vram_ready = 1'b1;
  logic [7:0]  vram_data = '0;
  logic [63:0] ent_x;
  logic [71:0] ent_pat;
  logic [23:0] ent_row;
  logic [3:0]  ent_count;
  logic        done, overflow;

  sprite_line_eval uut (.*);

  always #5 clk = ~clk;

  logic [7:0] tbl [256];
  int vectors = 0, fails = 0;
  bit stall_on = 0;
  int exp_y, y_reads, bad_addr;

  // memory: one cycle of read latency
  always @(posedge clk) if (vram_req && vram_ready) vram_data <= tbl[vram_addr[7:0]];

  // ready driver and address monitor (R1, R7, R11)
  initial forever begin
    @(negedge clk);
    vram_ready = stall_on ? (($urandom % 4) != 0) : 1'b1;
    #1;
    if (vram_req && vram_ready) begin
      if (vram_addr[13:8] != sat_base) bad_addr++;
      if (!vram_addr[7]) begin
        if (vram_addr[6] || vram_addr[5:0] != 6'(exp_y)) bad_addr++;
        exp_y++;
        y_reads++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  int m_cnt, m_nrd; bit m_ovf;
  logic [7:0] m_x [8];
  logic [8:0] m_pat [8];
  logic [2:0] m_row [8];

  task automatic model(input logic [7:0] ln);
    m_cnt = 0; m_ovf = 0; m_nrd = 0;
    for (int n = 0; n < 64; n++) begin
      logic [7:0] y, d, p, r;
      int h;
      y = tbl[n];
      m_nrd++;
      if (lines192 && y == 8'd208) break;               // R5
      d = ln - y - 8'd1;                                // R2
      h = 8 * (tall_en ? 2 : 1) * (zoom_en ? 2 : 1);    // R3
      if (int'(d) < h) begin
        if (m_cnt == 8) begin m_ovf = 1; break; end     // R4
        r = zoom_en ? (d >> 1) : d;
        p = tbl[8'h81 + 2*n];
        m_x[m_cnt]   = tbl[8'h80 + 2*n];                // R7
        m_pat[m_cnt] = {pat_bank, p[7:1], tall_en ? r[3] : p[0]}; // R8 R9
        m_row[m_cnt] = r[2:0];                          // R10
        m_cnt++;
      end
    end
  endtask

  task automatic run_scan(input logic [7:0] ln);
    int cyc, ovf_seen;
    model(ln);
    @(negedge clk);
    next_line = ln;
    exp_y = 0; y_reads = 0; bad_addr = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1; ovf_seen = 0;
    while (!done) begin
      if (overflow) ovf_seen++;
      @(negedge clk);
      cyc++;
    end
    if (overflow) ovf_seen++;
    check(ent_count == 4'(m_cnt), "R4", "count", ent_count, m_cnt);
    check(ovf_seen == (m_ovf ? 1 : 0), "R4", "overflow pulses", ovf_seen, m_ovf);
    check(y_reads == m_nrd, "R5", "y reads", y_reads, m_nrd);
    check(bad_addr == 0, "R1", "address errors", bad_addr, 0);
    if (!stall_on) check(cyc <= 342, "R12", "scan cycles", cyc, 342);
    for (int k = 0; k < m_cnt; k++) begin
      check(ent_x[k*8 +: 8] == m_x[k], "R6", "slot x", ent_x[k*8 +: 8], m_x[k]);
      check(ent_pat[k*9 +: 9] == m_pat[k], "R8", "slot pattern", ent_pat[k*9 +: 9], m_pat[k]);
      check(ent_row[k*3 +: 3] == m_row[k], "R10", "slot row", ent_row[k*3 +: 3], m_row[k]);
    end
    // R12: outputs hold after done
    repeat (3) @(negedge clk);
    check(done && ent_count == 4'(m_cnt) && !vram_req, "R12", "hold after done",
          ent_count, m_cnt);
  endtask

  task automatic fill_table(input int t);
    for (int n = 0; n < 64; n++) begin
      case (t)
        0: tbl[n] = 8'((n * 37 + 5) & 255);
        1: tbl[n] = 8'(100 + (n % 5));
        2: tbl[n] = (n == 20) ? 8'd208 : 8'(60 + 2 * n);
        default: tbl[n] = 8'(255 - 4 * n);
      endcase
      tbl[8'h80 + 2*n] = 8'((n * 3 + 1) ^ (t * 29));
      tbl[8'h81 + 2*n] = 8'(n * 5 + t * 17);
    end
    for (int a = 64; a < 128; a++) tbl[a] = 8'hEE;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL R12 watchdog: actual timeout expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int scans;
    scans = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!done && ent_count == 0 && !overflow && !vram_req, "R12", "reset state",
          {done, ent_count, overflow, vram_req}, 0);
    for (int t = 0; t < 4; t++) begin
      fill_table(t);
      sat_base = 6'(8'h10 + t * 13);
      for (int c = 0; c < 16; c++) begin
        tall_en = c[0]; zoom_en = c[1]; pat_bank = c[2]; lines192 = c[3];
        for (int i = 0; i < 16; i++) begin
          logic [7:0] ln;
          case (t)
            0: ln = 8'(i * 17);
            1: ln = 8'(96 + i * 3);
            2: ln = 8'(50 + i * 5);
            default: ln = 8'(i * 3);
          endcase
          stall_on = scans[0];
          run_scan(ln);
          scans++;
        end
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule